// File: doc/BRIEF.md
# E1 National-Bit Data Link Access

This block sits beside an existing E1 framer and gives access to the five national bits carried in timeslot 0 of every frame that does not hold the frame alignment word. The framer supplies the bit timing: a flag marking the current frame as a non-alignment frame, the timeslot number and the bit number inside the timeslot. Bits 4 to 8 of timeslot 0 (bit numbers 3 to 7 when counted from 0) carry the national bits. The first one sent or received is the most significant position.

On the receive side the block gathers all five national bits of each non-alignment frame. It loads them together into a readable register and pulses a one-cycle update strobe. It also drives a serial link data output that always carries the received stream. A link clock output beside it pulses only in the national-bit positions chosen by a 5-bit receive mask.

On the transmit side the outgoing serial stream passes through untouched except in the national-bit positions. There each bit comes from a transmit data register, or from an external serial link input when external sourcing is enabled and that position's bit in a 5-bit transmit mask is set. The transmit register is copied into a snapshot at the first bit of timeslot 0 of each non-alignment frame. A host write in the middle of the national bits therefore never yields a mixture of old and new values.

Top module: `e1_natbit_link`

## Requirements
- R1: After reset, the receive register reads 0, the update strobe and link clock are low, both masks and the external-source enable are 0, and the transmit data register holds all ones, so national-bit positions transmit 1.
- R2: National-bit positions are bit numbers 3 to 7 of timeslot 0 in frames with frame_nfas high. The bit at bit number 3 maps to register and mask bit 4, and the bit at bit number 7 maps to bit 0. Frames with frame_nfas low carry no national bits.
- R3: One cycle after the clock edge that samples the national bit at bit number 7, rx_sa holds all five bits of that frame and rx_sa_upd is high for exactly that one cycle. At all other times rx_sa keeps its value.
- R4: rx_link_data equals rx_ser delayed by one clock in every cycle, whatever the masks.
- R5: rx_link_clk is high in the cycle after a national-bit position whose receive mask bit is set. It is low in every other cycle. The receive mask is written at cfg_addr 1.
- R6: Outside national-bit positions, tx_ser_out equals tx_ser_in in the same cycle.
- R7: When the external-source enable (cfg_addr 3, data bit 0) is 0, every national-bit position transmits the matching bit of the snapshot, whatever the transmit mask.
- R8: When the external-source enable is 1, a national-bit position whose transmit mask bit (cfg_addr 2) is set transmits tx_link_in in the same cycle. A position whose mask bit is clear transmits the snapshot bit.
- R9: The transmit data register (cfg_addr 0) is copied to the snapshot at the clock edge of bit number 0 of timeslot 0 in a non-alignment frame. A write at any later bit of that frame takes effect from the next non-alignment frame.
- R10: With external sourcing enabled, transmit mask 5'h1F and tx_link_in tied to tx_ser_in, tx_ser_out equals tx_ser_in in every position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_nfas | input | 1 | Current frame is a non-alignment frame |
| ts_num | input | 5 | Current timeslot number |
| bit_num | input | 3 | Current bit inside the timeslot, 0 first |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 transmit data, 1 receive mask, 2 transmit mask, 3 control |
| cfg_wdata | input | 5 | Configuration write data |
| rx_ser | input | 1 | Received serial data |
| rx_sa | output | 5 | Last complete set of received national bits |
| rx_sa_upd | output | 1 | One-cycle strobe when rx_sa loads |
| rx_link_data | output | 1 | Receive link serial data |
| rx_link_clk | output | 1 | Receive link clock, gated by the receive mask |
| tx_ser_in | input | 1 | Transmit serial data from the framer |
| tx_link_in | input | 1 | External transmit link data |
| tx_ser_out | output | 1 | Transmit serial data with national bits inserted |

## Verification
The transmit output is combinational, so the bench checks it in the same cycle, a few nanoseconds after it drives the timing and link inputs. The receive link data and clock are registered and are due one edge after the bit that produced them. The bench checks them 1 ns after that edge against the inputs it drove in the previous cycle. The receive register and its strobe are due one edge after bit number 7. A host write lands on the same edge that takes the transmit snapshot, or after it, so the bench's model copies the snapshot before it applies the write. Every receive and transmit mask value is swept with pseudo-random data.

// File: rtl/e1_natbit_pkg.sv
package e1_natbit_pkg;

   // configuration register selects on cfg_addr
   typedef enum logic [1:0] {
      CFG_TXDATA = 2'd0,
      CFG_RXMASK = 2'd1,
      CFG_TXMASK = 2'd2,
      CFG_CTRL   = 2'd3
   } cfg_addr_e;

   localparam int DEF_NUM_SA   = 5;
   localparam int DEF_SA_FIRST = 3;
   localparam int DEF_BIT_W    = 3;
   localparam int DEF_TS_W     = 5;

endpackage

// File: rtl/natbit_slot_decode.sv
module natbit_slot_decode #(
   parameter int NUM_SA   = 5,
   parameter int SA_FIRST = 3,
   parameter int BIT_W    = 3,
   parameter int TS_W     = 5,
   parameter int SA_TS    = 0,
   localparam int IDX_W   = $clog2(NUM_SA)
) (
   input  logic             frame_nfas,
   input  logic [TS_W-1:0]  ts_num,
   input  logic [BIT_W-1:0] bit_num,
   output logic             sa_hit,
   output logic             sa_last,
   output logic             ts_start,
   output logic [IDX_W-1:0] sa_idx
);
   int   rel;
   logic slot;

   always_comb begin
      rel      = int'(bit_num) - SA_FIRST;
      slot     = frame_nfas && (ts_num == TS_W'(SA_TS));
      sa_hit   = slot && (rel >= 0) && (rel < NUM_SA);
      sa_last  = slot && (rel == NUM_SA - 1);
      ts_start = slot && (bit_num == '0);
      sa_idx   = IDX_W'(NUM_SA - 1 - rel);
   end
endmodule

// File: rtl/natbit_rx_capture.sv
module natbit_rx_capture #(
   parameter int NUM_SA      = 5,
   parameter bit RX_LINK_REG = 1'b1,
   localparam int IDX_W      = $clog2(NUM_SA)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sa_hit,
   input  logic              sa_last,
   input  logic [IDX_W-1:0]  sa_idx,
   input  logic              rx_ser,
   input  logic [NUM_SA-1:0] rx_mask,
   output logic [NUM_SA-1:0] rx_sa,
   output logic              rx_sa_upd,
   output logic              rx_link_data,
   output logic              rx_link_clk
);
   logic [NUM_SA-1:0] shift_q;
   logic              gate_now;

   assign gate_now = sa_hit & rx_mask[sa_idx];

   always_ff @(posedge clk) begin
      if (rst) begin
         shift_q   <= '0;
         rx_sa     <= '0;
         rx_sa_upd <= 1'b0;
      end else begin
         rx_sa_upd <= 1'b0;
         if (sa_hit) begin
            shift_q <= {shift_q[NUM_SA-2:0], rx_ser};
         end
         if (sa_last) begin
            rx_sa     <= {shift_q[NUM_SA-2:0], rx_ser};
            rx_sa_upd <= 1'b1;
         end
      end
   end

   generate
      if (RX_LINK_REG) begin : g_link_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               rx_link_data <= 1'b0;
               rx_link_clk  <= 1'b0;
            end else begin
               rx_link_data <= rx_ser;
               rx_link_clk  <= gate_now;
            end
         end

         // R5
         link_clk_gate_chk: assert property (@(posedge clk) disable iff (rst)
            rx_link_clk |-> $past(sa_hit));
      end else begin : g_link_comb
         assign rx_link_data = rx_ser;
         assign rx_link_clk  = gate_now;
      end
   endgenerate

   // R3
   rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !rx_sa_upd |-> $stable(rx_sa));

   // R3
   rx_upd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      rx_sa_upd |=> !rx_sa_upd);
endmodule

// File: rtl/natbit_tx_insert.sv
module natbit_tx_insert #(
   parameter int NUM_SA = 5,
   localparam int IDX_W = $clog2(NUM_SA)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ts_start,
   input  logic              sa_hit,
   input  logic [IDX_W-1:0]  sa_idx,
   input  logic              ext_en,
   input  logic [NUM_SA-1:0] tx_mask,
   input  logic [NUM_SA-1:0] tx_data,
   input  logic              tx_ser_in,
   input  logic              tx_link_in,
   output logic              tx_ser_out
);
   logic [NUM_SA-1:0] snap_q;
   logic [NUM_SA-1:0] bit_val;

   always_ff @(posedge clk) begin
      if (rst) begin
         snap_q <= '1;
      end else if (ts_start) begin
         snap_q <= tx_data;
      end
   end

   generate
      for (genvar i = 0; i < NUM_SA; i++) begin : g_src
         assign bit_val[i] = (ext_en & tx_mask[i]) ? tx_link_in : snap_q[i];
      end
   endgenerate

   assign tx_ser_out = sa_hit ? bit_val[sa_idx] : tx_ser_in;

   // R6
   tx_pass_chk: assert property (@(posedge clk) disable iff (rst)
      !sa_hit |-> (tx_ser_out == tx_ser_in));

   // R7
   tx_internal_chk: assert property (@(posedge clk) disable iff (rst)
      (sa_hit && !ext_en) |-> (tx_ser_out == snap_q[sa_idx]));

   // R8
   tx_external_chk: assert property (@(posedge clk) disable iff (rst)
      (sa_hit && ext_en && tx_mask[sa_idx]) |-> (tx_ser_out == tx_link_in));

   // R9
   snap_window_chk: assert property (@(posedge clk) disable iff (rst)
      !ts_start |=> $stable(snap_q));
endmodule

// File: rtl/e1_natbit_link.sv
module e1_natbit_link
   import e1_natbit_pkg::*;
#(
   parameter int NUM_SA      = DEF_NUM_SA,
   parameter int SA_FIRST    = DEF_SA_FIRST,
   parameter int BIT_W       = DEF_BIT_W,
   parameter int TS_W        = DEF_TS_W,
   parameter int SA_TS       = 0,
   parameter bit RX_LINK_REG = 1'b1,
   localparam int IDX_W      = $clog2(NUM_SA)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              frame_nfas,
   input  logic [TS_W-1:0]   ts_num,
   input  logic [BIT_W-1:0]  bit_num,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_addr,
   input  logic [NUM_SA-1:0] cfg_wdata,
   input  logic              rx_ser,
   output logic [NUM_SA-1:0] rx_sa,
   output logic              rx_sa_upd,
   output logic              rx_link_data,
   output logic              rx_link_clk,
   input  logic              tx_ser_in,
   input  logic              tx_link_in,
   output logic              tx_ser_out
);
   generate
      if (NUM_SA < 2 || SA_FIRST < 0 || (SA_FIRST + NUM_SA) > (1 << BIT_W)) begin : g_bad_slot
         $error("national-bit field does not fit the timeslot");
      end
      if (SA_TS < 0 || SA_TS >= (1 << TS_W)) begin : g_bad_ts
         $error("carrier timeslot out of range");
      end
   endgenerate

   logic [NUM_SA-1:0] tx_data_q, rx_mask_q, tx_mask_q;
   logic              ext_en_q;
   logic              sa_hit, sa_last, ts_start;
   logic [IDX_W-1:0]  sa_idx;

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_data_q <= '1;
         rx_mask_q <= '0;
         tx_mask_q <= '0;
         ext_en_q  <= 1'b0;
      end else if (cfg_wr) begin
         case (cfg_addr_e'(cfg_addr))
            CFG_TXDATA: tx_data_q <= cfg_wdata;
            CFG_RXMASK: rx_mask_q <= cfg_wdata;
            CFG_TXMASK: tx_mask_q <= cfg_wdata;
            CFG_CTRL:   ext_en_q  <= cfg_wdata[0];
            default:    ;
         endcase
      end
   end

   natbit_slot_decode #(
      .NUM_SA(NUM_SA), .SA_FIRST(SA_FIRST), .BIT_W(BIT_W),
      .TS_W(TS_W), .SA_TS(SA_TS)
   ) u_decode (
      .frame_nfas(frame_nfas), .ts_num(ts_num), .bit_num(bit_num),
      .sa_hit(sa_hit), .sa_last(sa_last), .ts_start(ts_start), .sa_idx(sa_idx)
   );

   natbit_rx_capture #(.NUM_SA(NUM_SA), .RX_LINK_REG(RX_LINK_REG)) u_rx (
      .clk(clk), .rst(rst), .sa_hit(sa_hit), .sa_last(sa_last), .sa_idx(sa_idx),
      .rx_ser(rx_ser), .rx_mask(rx_mask_q), .rx_sa(rx_sa), .rx_sa_upd(rx_sa_upd),
      .rx_link_data(rx_link_data), .rx_link_clk(rx_link_clk)
   );

   natbit_tx_insert #(.NUM_SA(NUM_SA)) u_tx (
      .clk(clk), .rst(rst), .ts_start(ts_start), .sa_hit(sa_hit), .sa_idx(sa_idx),
      .ext_en(ext_en_q), .tx_mask(tx_mask_q), .tx_data(tx_data_q),
      .tx_ser_in(tx_ser_in), .tx_link_in(tx_link_in), .tx_ser_out(tx_ser_out)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      $past(rst) |-> (rx_sa == '0 && !rx_sa_upd && !rx_link_clk));
endmodule

// File: tb/tb_e1_natbit_link.sv
`timescale 1ns/1ps
module tb_e1_natbit_link;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       frame_nfas = 1'b0;
   logic [4:0] ts_num = '0;
   logic [2:0] bit_num = '0;
   logic       cfg_wr = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [4:0] cfg_wdata = '0;
   logic       rx_ser = 1'b0;
   logic       tx_ser_in = 1'b0;
   logic       tx_link_in = 1'b0;
   logic [4:0] rx_sa;
   logic       rx_sa_upd, rx_link_data, rx_link_clk, tx_ser_out;

   e1_natbit_link dut (
      .clk(clk), .rst(rst), .frame_nfas(frame_nfas), .ts_num(ts_num), .bit_num(bit_num),
      .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rx_ser(rx_ser),
      .rx_sa(rx_sa), .rx_sa_upd(rx_sa_upd), .rx_link_data(rx_link_data),
      .rx_link_clk(rx_link_clk), .tx_ser_in(tx_ser_in), .tx_link_in(tx_link_in),
      .tx_ser_out(tx_ser_out)
   );

   always #10 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   logic [15:0] lfsr = 16'hACE1;
   logic [4:0]  m_txreg = 5'h1F, m_snap = 5'h1F, m_rxmask = '0, m_txmask = '0;
   logic [4:0]  m_shift = '0, m_rxsa = '0;
   logic        m_ext = 1'b0;
   string       tx_tag = "";

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cfg_write(input logic [1:0] a, input logic [4:0] d);
      frame_nfas = 1'b0; cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk);
      case (a)
         2'd0: m_txreg = d;
         2'd1: m_rxmask = d;
         2'd2: m_txmask = d;
         default: m_ext = d[0];
      endcase
      #1 cfg_wr = 1'b0;
   endtask

   // one full frame of 32 timeslots; wr_bit >= 0 writes transmit data at that bit of timeslot 0
   task automatic run_frame(input logic odd, input logic tie_link, input int wr_bit,
                            input logic [4:0] wr_val);
      for (int ts = 0; ts < 32; ts++) begin
         for (int b = 0; b < 8; b++) begin
            logic hit, rxb, txb, lkb, exp_tx, do_wr;
            int   ridx;
            string tg;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rxb = lfsr[0]; txb = lfsr[5]; lkb = tie_link ? txb : lfsr[9];
            do_wr = odd && ts == 0 && b == wr_bit;
            frame_nfas = odd; ts_num = 5'(ts); bit_num = 3'(b);
            rx_ser = rxb; tx_ser_in = txb; tx_link_in = lkb;
            cfg_wr = do_wr; cfg_addr = 2'd0; cfg_wdata = wr_val;
            hit  = odd && ts == 0 && b >= 3;
            ridx = 7 - b;
            if (!hit) begin
               exp_tx = txb; tg = "R6";
            end else if (m_ext && m_txmask[ridx]) begin
               exp_tx = lkb; tg = tie_link ? "R10" : "R8";
            end else begin
               exp_tx = m_snap[ridx]; tg = m_ext ? "R8" : "R7";
            end
            if (hit && tx_tag != "") tg = tx_tag;
            #5 chk(tg, 8'(tx_ser_out), 8'(exp_tx));
            @(posedge clk);
            if (odd && ts == 0 && b == 0) m_snap = m_txreg;
            if (do_wr) m_txreg = wr_val;
            if (hit) m_shift = {m_shift[3:0], rxb};
            if (hit && b == 7) m_rxsa = m_shift;
            #1;
            chk("R4", 8'(rx_link_data), 8'(rxb));
            chk("R5", 8'(rx_link_clk), 8'(hit && m_rxmask[ridx]));
            chk("R3", 8'(rx_sa_upd), 8'(hit && b == 7));
            chk("R2", 8'(rx_sa), 8'(m_rxsa));
            cfg_wr = 1'b0;
         end
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      #5;
      // R1 reset state
      chk("R1", 8'(rx_sa), 8'h00);
      chk("R1", 8'(rx_sa_upd), 8'h0);
      chk("R1", 8'(rx_link_clk), 8'h0);
      tx_tag = "R1";
      run_frame(1'b0, 1'b0, -1, '0);
      run_frame(1'b1, 1'b0, -1, '0);
      tx_tag = "";

      // R5 sweep of every receive mask, even and odd frames
      for (int m = 0; m < 32; m++) begin
         cfg_write(2'd1, 5'(m));
         run_frame(1'b0, 1'b0, -1, '0);
         run_frame(1'b1, 1'b0, -1, '0);
      end

      // R7 internal source, mask ignored
      cfg_write(2'd2, 5'h1F);
      cfg_write(2'd0, 5'h0A);
      run_frame(1'b1, 1'b0, -1, '0);
      cfg_write(2'd0, 5'h15);
      run_frame(1'b1, 1'b0, -1, '0);

      // R8 sweep of every transmit mask with external source on
      cfg_write(2'd3, 5'h01);
      for (int m = 0; m < 32; m++) begin
         cfg_write(2'd2, 5'(m));
         cfg_write(2'd0, 5'(m) ^ 5'h13);
         run_frame(1'b0, 1'b0, -1, '0);
         run_frame(1'b1, 1'b0, -1, '0);
      end

      // R10 transparent pass-through
      cfg_write(2'd2, 5'h1F);
      run_frame(1'b1, 1'b1, -1, '0);
      run_frame(1'b1, 1'b1, -1, '0);

      // R9 snapshot timing with writes during timeslot 0
      cfg_write(2'd3, 5'h00);
      cfg_write(2'd0, 5'h00);
      tx_tag = "R9";
      run_frame(1'b1, 1'b0, 5, 5'h1F);
      run_frame(1'b1, 1'b0, 0, 5'h05);
      run_frame(1'b1, 1'b0, 7, 5'h1A);
      run_frame(1'b1, 1'b0, -1, '0);
      tx_tag = "";

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule